// File: doc/BRIEF.md
# Board System Control Register Bank

This block is a byte-wide bank of board control and identification registers on a simple I/O port bus. Each bus cycle presents an address, write data, a write strobe and a read strobe. A handful of writable registers drive board-level control pins: a soft-reset request, a little-endian mode flag, a disk activity light, a four-bit cache-control value and an I/O map mode bit that an external address translator consumes. Two password ports store nothing; a write to either one emits a single-cycle toggle request towards an external NVRAM lock. The remaining ports return fixed identification and status bytes.

The bus has no back-pressure. The bank accepts every strobe in the cycle it is presented, so it has no ready signal. Read data leaves through a registered output that carries a valid flag, and a downstream consumer must take it in the cycle that flag is high because there is no hold-off. A write to an address the bank does not decode is flagged for one cycle on an error output and changes nothing.

Top module: `sysctl_bank`

## Requirements
- R1: A write to address 0x0092 sets `reset_req` to data bit 0 and `le_mode` to data bit 1, visible the cycle after the write strobe, and both hold until the next write to that address.
- R2: A read of address 0x0092 returns 0x00.
- R3: A write to address 0x0808 sets `disk_led` to data bit 0. The other data bits have no effect.
- R4: A write to 0x0810 raises `lock1_pulse`, and a write to 0x0812 raises `lock2_pulse`. Either pulse is high for exactly the one cycle after the strobe. Neither port stores data, so a read of 0x0810 still returns 0x39 and a read of 0x0812 returns 0xFF.
- R5: A write to 0x081C stores data bits 3:0 on `ctl_nib`. A read of 0x081C returns the stored value in bits 3:0, with bits 7:4 zero.
- R6: A write to 0x0850 stores data bit 0 on `map_mode`. A read of 0x0850 returns that bit in bit 0, with bits 7:1 zero.
- R7: Reads of the identification ports return constants: 0x0800 gives 0xEF, 0x0802 gives 0xAD, 0x0803 gives 0xE0, 0x080C gives 0x3C, 0x0810 gives 0x39, 0x0818 gives 0x00 and 0x0823 gives 0x03.
- R8: Writes to 0x0800, 0x0802, 0x0803 and 0x0814 are accepted without `wr_err` and change no output or readable value. A read of 0x0814 returns 0xFF.
- R9: A read of any address not listed in R2, R5, R6 or R7 returns 0xFF. This includes 0x0808 and 0x0812.
- R10: A write to any address not listed in R1, R3, R4, R5, R6 or R8 raises `wr_err` for exactly the next cycle and changes no state.
- R11: With `rst` high at a clock edge, all writable state, `rdata`, `rdata_vld`, the pulses and `wr_err` are zero after that edge.
- R12: `rdata_vld` is high in exactly the cycle after each cycle with `rd_en` high, and `rdata` carries the value for that read. A read in the same cycle as a write returns the value held before the write. Back-to-back reads give back-to-back results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Port address for the current strobe |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| rdata_vld | output | 1 | Read data valid, one cycle after `rd_en` |
| reset_req | output | 1 | Soft-reset request level |
| le_mode | output | 1 | Little-endian mode flag |
| disk_led | output | 1 | Disk activity light |
| ctl_nib | output | 4 | Cache-control value |
| map_mode | output | 1 | I/O map mode for the address translator |
| lock1_pulse | output | 1 | NVRAM lock toggle request, bank 1 |
| lock2_pulse | output | 1 | NVRAM lock toggle request, bank 2 |
| wr_err | output | 1 | Write to an undecoded address |

## Verification
The bench targets the asymmetry between the read and write decodes. 0x0810 reads as a constant but pulses on a write. 0x0812 and 0x0808 are writable but read as 0xFF. A design that shared one decode for both directions would return stored data there or would miss a pulse. Masking is checked with wide data patterns, so a control register that stored more than its defined bits would show stray ones on a readback. Writes to read-only and undecoded ports are followed by readbacks and output checks, which catch any write that leaks into state. A read in the same cycle as a write, back-to-back reads and a reset in mid-run expose a read path that samples after the update or that fails to clear.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int DW    = 8;
  localparam int CTL_W = 4;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_P92, SEL_CPUCFG, SEL_FEAT, SEL_MODSTAT, SEL_LIGHT,
    SEL_EQUIP, SEL_LOCK1, SEL_LOCK2, SEL_L2INV, SEL_KEY, SEL_SYSCTL,
    SEL_L2STAT, SEL_MAPTYPE
  } sel_e;

  localparam logic [15:0] A_P92     = 16'h0092;
  localparam logic [15:0] A_CPUCFG  = 16'h0800;
  localparam logic [15:0] A_FEAT    = 16'h0802;
  localparam logic [15:0] A_MODSTAT = 16'h0803;
  localparam logic [15:0] A_LIGHT   = 16'h0808;
  localparam logic [15:0] A_EQUIP   = 16'h080C;
  localparam logic [15:0] A_LOCK1   = 16'h0810;
  localparam logic [15:0] A_LOCK2   = 16'h0812;
  localparam logic [15:0] A_L2INV   = 16'h0814;
  localparam logic [15:0] A_KEY     = 16'h0818;
  localparam logic [15:0] A_SYSCTL  = 16'h081C;
  localparam logic [15:0] A_L2STAT  = 16'h0823;
  localparam logic [15:0] A_MAPTYPE = 16'h0850;

  localparam logic [DW-1:0] V_CPUCFG  = 8'hEF;
  localparam logic [DW-1:0] V_FEAT    = 8'hAD;
  localparam logic [DW-1:0] V_MODSTAT = 8'hE0;
  localparam logic [DW-1:0] V_EQUIP   = 8'h3C;
  localparam logic [DW-1:0] V_EXTFEAT = 8'h39;
  localparam logic [DW-1:0] V_KEY     = 8'h00;
  localparam logic [DW-1:0] V_L2STAT  = 8'h03;
  localparam logic [DW-1:0] V_EMPTY   = 8'hFF;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel,
  output logic              wr_ok,
  output logic              rd_ok
);
  always_comb begin
    if (addr == ADDR_W'(A_P92))          sel = SEL_P92;
    else if (addr == ADDR_W'(A_CPUCFG))  sel = SEL_CPUCFG;
    else if (addr == ADDR_W'(A_FEAT))    sel = SEL_FEAT;
    else if (addr == ADDR_W'(A_MODSTAT)) sel = SEL_MODSTAT;
    else if (addr == ADDR_W'(A_LIGHT))   sel = SEL_LIGHT;
    else if (addr == ADDR_W'(A_EQUIP))   sel = SEL_EQUIP;
    else if (addr == ADDR_W'(A_LOCK1))   sel = SEL_LOCK1;
    else if (addr == ADDR_W'(A_LOCK2))   sel = SEL_LOCK2;
    else if (addr == ADDR_W'(A_L2INV))   sel = SEL_L2INV;
    else if (addr == ADDR_W'(A_KEY))     sel = SEL_KEY;
    else if (addr == ADDR_W'(A_SYSCTL))  sel = SEL_SYSCTL;
    else if (addr == ADDR_W'(A_L2STAT))  sel = SEL_L2STAT;
    else if (addr == ADDR_W'(A_MAPTYPE)) sel = SEL_MAPTYPE;
    else                                 sel = SEL_NONE;
  end

  always_comb begin
    case (sel)
      SEL_P92, SEL_CPUCFG, SEL_FEAT, SEL_MODSTAT, SEL_LIGHT, SEL_LOCK1,
      SEL_LOCK2, SEL_L2INV, SEL_SYSCTL, SEL_MAPTYPE: wr_ok = 1'b1;
      default:                                       wr_ok = 1'b0;
    endcase
    case (sel)
      SEL_P92, SEL_CPUCFG, SEL_FEAT, SEL_MODSTAT, SEL_EQUIP, SEL_LOCK1,
      SEL_KEY, SEL_SYSCTL, SEL_L2STAT, SEL_MAPTYPE: rd_ok = 1'b1;
      default:                                      rd_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  sel_e             sel,
  input  logic             wr_ok,
  input  logic [DW-1:0]    wdata,
  output logic             reset_req,
  output logic             le_mode,
  output logic             disk_led,
  output logic [CTL_W-1:0] ctl_nib,
  output logic             map_mode,
  output logic             lock1_pulse,
  output logic             lock2_pulse,
  output logic             wr_err
);
  logic do_wr;
  assign do_wr = wr_en && wr_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      reset_req   <= 1'b0;
      le_mode     <= 1'b0;
      disk_led    <= 1'b0;
      ctl_nib     <= '0;
      map_mode    <= 1'b0;
      lock1_pulse <= 1'b0;
      lock2_pulse <= 1'b0;
      wr_err      <= 1'b0;
    end else begin
      lock1_pulse <= do_wr && (sel == SEL_LOCK1);
      lock2_pulse <= do_wr && (sel == SEL_LOCK2);
      wr_err      <= wr_en && !wr_ok;
      if (do_wr) begin
        case (sel)
          SEL_P92: begin
            reset_req <= wdata[0];
            le_mode   <= wdata[1];
          end
          SEL_LIGHT:   disk_led <= wdata[0];
          SEL_SYSCTL:  ctl_nib  <= wdata[CTL_W-1:0];
          SEL_MAPTYPE: map_mode <= wdata[0];
          default: ;
        endcase
      end
    end
  end

  // R11
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!reset_req && !le_mode && !disk_led && ctl_nib == '0 &&
             !map_mode && !lock1_pulse && !lock2_pulse && !wr_err));

  // R5
  ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && sel == SEL_SYSCTL) |=> $stable(ctl_nib));

  // R10
  bad_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_NONE) |=> (wr_err && $stable(map_mode) &&
                                    $stable(reset_req) && $stable(le_mode)));
endmodule

// File: rtl/sysctl_rdpath.sv
module sysctl_rdpath
  import sysctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  sel_e             sel,
  input  logic             rd_ok,
  input  logic [CTL_W-1:0] ctl_nib,
  input  logic             map_mode,
  output logic [DW-1:0]    rdata,
  output logic             rdata_vld
);
  logic [DW-1:0] rd_val;

  always_comb begin
    rd_val = V_EMPTY;
    if (rd_ok) begin
      case (sel)
        SEL_P92:     rd_val = '0;
        SEL_CPUCFG:  rd_val = V_CPUCFG;
        SEL_FEAT:    rd_val = V_FEAT;
        SEL_MODSTAT: rd_val = V_MODSTAT;
        SEL_EQUIP:   rd_val = V_EQUIP;
        SEL_LOCK1:   rd_val = V_EXTFEAT;
        SEL_KEY:     rd_val = V_KEY;
        SEL_L2STAT:  rd_val = V_L2STAT;
        SEL_SYSCTL:  rd_val = DW'(ctl_nib);
        SEL_MAPTYPE: rd_val = DW'(map_mode);
        default:     rd_val = V_EMPTY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata     <= '0;
      rdata_vld <= 1'b0;
    end else begin
      rdata_vld <= rd_en;
      if (rd_en) rdata <= rd_val;
    end
  end

  // R12
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rdata_vld);

  // R12
  vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rdata_vld);

  // R9
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_NONE) |=> rdata == V_EMPTY);

  // R2
  p92_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_P92) |=> rdata == '0);
endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [7:0]        rdata,
  output logic              rdata_vld,
  output logic              reset_req,
  output logic              le_mode,
  output logic              disk_led,
  output logic [3:0]        ctl_nib,
  output logic              map_mode,
  output logic              lock1_pulse,
  output logic              lock2_pulse,
  output logic              wr_err
);
  sel_e sel;
  logic wr_ok, rd_ok;

  sysctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .sel(sel), .wr_ok(wr_ok), .rd_ok(rd_ok)
  );

  sysctl_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .sel(sel), .wr_ok(wr_ok),
    .wdata(wdata), .reset_req(reset_req), .le_mode(le_mode),
    .disk_led(disk_led), .ctl_nib(ctl_nib), .map_mode(map_mode),
    .lock1_pulse(lock1_pulse), .lock2_pulse(lock2_pulse), .wr_err(wr_err)
  );

  sysctl_rdpath u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .sel(sel), .rd_ok(rd_ok),
    .ctl_nib(ctl_nib), .map_mode(map_mode), .rdata(rdata),
    .rdata_vld(rdata_vld)
  );

  // R4
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lock1_pulse, lock2_pulse, wr_err}));

  // R4
  lock1_once_chk: assert property (@(posedge clk) disable iff (rst)
    (lock1_pulse && !(wr_en && addr == ADDR_W'(A_LOCK1))) |=> !lock1_pulse);
endmodule

// File: tb/test_sysctl_bank.sv
module test_sysctl_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  rdata;
  logic        rdata_vld, reset_req, le_mode, disk_led, map_mode;
  logic [3:0]  ctl_nib;
  logic        lock1_pulse, lock2_pulse, wr_err;

  int nchk = 0;
  int nfail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  sysctl_bank #(.ADDR_W(16)) i_sysctl_bank (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .rdata_vld(rdata_vld),
    .reset_req(reset_req), .le_mode(le_mode), .disk_led(disk_led),
    .ctl_nib(ctl_nib), .map_mode(map_mode), .lock1_pulse(lock1_pulse),
    .lock2_pulse(lock2_pulse), .wr_err(wr_err)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // driver: one strobe per call, returns at the negedge after the capturing edge
  task automatic wr(logic [15:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, logic [7:0] e, string tag);
    addr = a; rd_en = 1'b1; wr_en = 1'b0;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic outs(string tag, logic rr, logic le, logic led,
                      logic [3:0] cn, logic mm);
    check({tag, " reset_req"}, 32'(reset_req), 32'(rr));
    check({tag, " le_mode"},   32'(le_mode),   32'(le));
    check({tag, " disk_led"},  32'(disk_led),  32'(led));
    check({tag, " ctl_nib"},   32'(ctl_nib),   32'(cn));
    check({tag, " map_mode"},  32'(map_mode),  32'(mm));
  endtask

  // monitor: compares each valid read result against the scoreboard
  always @(negedge clk) begin
    if (!rst && rdata_vld) begin
      if (exp_q.size() == 0) begin
        nchk++; nfail++;
        $display("FAIL R12: unexpected rdata_vld, actual 0x%0h expected none", rdata);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, 32'(rdata), 32'(e));
      end
    end
  end

  initial begin
    #1500000;
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    outs("R11 reset", 0, 0, 0, 4'h0, 0);
    check("R11 rdata_vld", 32'(rdata_vld), 0);
    check("R11 pulses", 32'({lock1_pulse, lock2_pulse, wr_err}), 0);

    // R1
    wr(16'h0092, 8'h03); outs("R1 both", 1, 1, 0, 0, 0);
    wr(16'h0092, 8'hFE); outs("R1 le only", 0, 1, 0, 0, 0);
    wr(16'h0092, 8'h01); outs("R1 reset only", 1, 0, 0, 0, 0);
    @(negedge clk); outs("R1 hold", 1, 0, 0, 0, 0);
    // R2
    rd(16'h0092, 8'h00, "R2 read 0092");

    // R3
    wr(16'h0808, 8'hFE); check("R3 led off", 32'(disk_led), 0);
    wr(16'h0808, 8'h01); check("R3 led on", 32'(disk_led), 1);

    // R4
    wr(16'h0810, 8'h55);
    check("R4 lock1 pulse", 32'(lock1_pulse), 1);
    check("R4 lock2 idle", 32'(lock2_pulse), 0);
    @(negedge clk); check("R4 lock1 one cycle", 32'(lock1_pulse), 0);
    wr(16'h0812, 8'hAA);
    check("R4 lock2 pulse", 32'(lock2_pulse), 1);
    check("R4 lock1 idle", 32'(lock1_pulse), 0);
    @(negedge clk); check("R4 lock2 one cycle", 32'(lock2_pulse), 0);
    rd(16'h0810, 8'h39, "R4 read 0810 unchanged");
    rd(16'h0812, 8'hFF, "R4 read 0812 no store");

    // R5
    wr(16'h081C, 8'hA7); check("R5 ctl_nib masked", 32'(ctl_nib), 32'h7);
    rd(16'h081C, 8'h07, "R5 read 081C");

    // R6
    wr(16'h0850, 8'hFF); check("R6 map set", 32'(map_mode), 1);
    rd(16'h0850, 8'h01, "R6 read 0850 set");
    wr(16'h0850, 8'h02); check("R6 map clear", 32'(map_mode), 0);
    rd(16'h0850, 8'h00, "R6 read 0850 clear");
    wr(16'h0850, 8'h01);

    // R7 fixed values, back to back (R12)
    rd(16'h0800, 8'hEF, "R7 0800");
    rd(16'h0802, 8'hAD, "R7 0802");
    rd(16'h0803, 8'hE0, "R7 0803");
    rd(16'h080C, 8'h3C, "R7 080C");
    rd(16'h0810, 8'h39, "R7 0810");
    rd(16'h0818, 8'h00, "R7 0818");
    rd(16'h0823, 8'h03, "R7 0823 R12 back-to-back");

    // R8 read-only and no-effect writes
    wr(16'h0800, 8'h00); check("R8 0800 no err", 32'(wr_err), 0);
    wr(16'h0802, 8'h00); check("R8 0802 no err", 32'(wr_err), 0);
    wr(16'h0803, 8'h00); check("R8 0803 no err", 32'(wr_err), 0);
    wr(16'h0814, 8'hFF); check("R8 0814 no err", 32'(wr_err), 0);
    outs("R8 state kept", 1, 0, 1, 4'h7, 1);
    rd(16'h0800, 8'hEF, "R8 0800 still fixed");
    rd(16'h0803, 8'hE0, "R8 0803 still fixed");
    rd(16'h0814, 8'hFF, "R8 read 0814");

    // R9 unmapped reads
    rd(16'h0801, 8'hFF, "R9 0801");
    rd(16'h0808, 8'hFF, "R9 0808");
    rd(16'h0000, 8'hFF, "R9 0000");
    rd(16'h0851, 8'hFF, "R9 0851");
    rd(16'hFFFF, 8'hFF, "R9 FFFF");

    // R10 unmapped writes
    wr(16'h0818, 8'hFF); check("R10 err 0818", 32'(wr_err), 1);
    @(negedge clk); check("R10 err one cycle", 32'(wr_err), 0);
    wr(16'h0093, 8'h00); check("R10 err 0093", 32'(wr_err), 1);
    wr(16'h081D, 8'h00); check("R10 err back-to-back", 32'(wr_err), 1);
    outs("R10 state kept", 1, 0, 1, 4'h7, 1);
    rd(16'h081C, 8'h07, "R10 081C kept");

    // R12 read in the same cycle as a write returns the old value
    addr = 16'h081C; wdata = 8'h03; wr_en = 1'b1; rd_en = 1'b1;
    exp_q.push_back(8'h07); tag_q.push_back("R12 read during write");
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R12 write landed", 32'(ctl_nib), 32'h3);
    @(negedge clk);
    check("R12 vld idle", 32'(rdata_vld), 0);

    // R11 mid-run reset
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    outs("R11 mid-run", 0, 0, 0, 4'h0, 0);
    rd(16'h081C, 8'h00, "R11 081C cleared");
    rd(16'h0850, 8'h00, "R11 0850 cleared");

    repeat (3) @(negedge clk);
    check("R12 scoreboard drained", 32'(exp_q.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule